// File: doc/BRIEF.md
# UART Register File with Interrupt Prioritisation

This block is the host-facing register bank of a PC-style serial port. A byte-wide bus with a three-bit offset, a read strobe and a write strobe reaches eight byte registers. Through them software sets the frame format, programs a 16-bit baud divisor and unmasks interrupt sources. It also exchanges data bytes with separate transmit and receive shifters, reads line and modem status, and uses a spare scratch byte. The shifters are outside the block. The transmitter receives a one-cycle load strobe with the byte and returns an accept strobe. The receiver delivers a byte strobe or a break strobe.

Two interrupt sources, receive data and transmitter holding empty, are merged into a three-bit identification code with fixed priority. That code drives a single level-sensitive interrupt line. The transmit source is remembered in a hidden pending flag. Reading the identification register while it reports that source clears the flag. Writing the enable register while the holding register is empty arms the flag again. A loopback mode folds the modem-control output bits back onto the modem-status read.

Read data is combinational. It is valid in the same cycle as the read strobe. Every side effect of a read or write takes place at the following clock edge.

Top module: `uart_regfile`

## Requirements
- R1: The 3-bit offset selects a register. While line-control bit 7 is 1, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8, instead of the data and enable registers. The `divisor` output always shows the stored 16-bit value.
- R2: After reset, line status reads 0x60, identification reads 0x01 and modem status reads 0xB0. The enable, line-control, modem-control, scratch and divisor registers read 0, and `irq` is low.
- R3: A write to offset 1, with bit 7 of line control clear, stores only data bits 3:0 into the enable register. Enable bit 0 unmasks receive data and bit 1 unmasks transmit. If line-status bit 5 is set at that edge, the transmit pending flag becomes set.
- R4: The identification code is 0x04 when data-ready and enable bit 0 are both set. Otherwise it is 0x02 when transmit pending and enable bit 1 are both set. Otherwise it is 0x01. `irq` is high exactly when the code is not 0x01.
- R5: Reading offset 2 while it returns 0x02 clears transmit pending, unless `tx_accept` arrives in the same cycle.
- R6: A write to offset 0, with bit 7 of line control clear, pulses `tx_load` in that same cycle with `tx_byte` equal to the written data. It clears line-status bits 5 and 6 and transmit pending. A later `tx_accept` sets all three again. A write wins over an accept in the same cycle.
- R7: `rx_byte_valid` loads `rx_byte` into the receive buffer and sets data-ready (line-status bit 0). Reading offset 0, with bit 7 of line control clear, clears data-ready and break (line-status bit 4). A byte arriving in the same cycle wins.
- R8: `rx_break` loads 0x00 into the receive buffer and sets break and data-ready. It takes precedence over a byte arriving in the same cycle.
- R9: A byte or break that arrives while data-ready is set, and while the buffer is not being read in that cycle, sets overrun (line-status bit 1). Reading offset 5 clears overrun unless a new overrun occurs in the same cycle.
- R10: A write to offset 4 keeps only bits 4:0. While bit 4 is set, offset 6 reads modem-control bits 3:2 on bits 7:6, bit 0 on bit 5 and bit 1 on bit 4, with zeros elsewhere. Otherwise offset 6 reads 0xB0.
- R11: Offsets 3 and 7 are plain read/write bytes, and offset 3 drives `line_ctrl`. Writes to offsets 2, 5 and 6 change nothing.
- R12: `rdata` shows the selected register in the cycle `rd_en` is high and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| irq | output | 1 | Level interrupt |
| divisor | output | 16 | Baud divisor for the rate generator |
| line_ctrl | output | 8 | Line-control byte for the shifters |
| tx_load | output | 1 | Transmit load strobe |
| tx_byte | output | 8 | Byte handed to the transmitter |
| tx_accept | input | 1 | Transmitter took the byte |
| rx_byte_valid | input | 1 | Receiver delivers a byte |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Receiver detected a break |

## Verification
The bench targets the hidden transmit flag. A design that cleared it on any identification read, or that did not re-arm it from an enable write, would keep `irq` stuck high or leave it silent after software had serviced the interrupt. It collides arrivals with buffer and status reads in the same cycle. A design that let the read win would lose a byte or report a false or missing overrun. Loopback reads with asymmetric modem-control patterns expose swapped bit lanes, and divisor-access toggling exposes designs that still load the transmitter or the enable register while the divisor is selected.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IIR  = 3'd2;
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_MCR  = 3'd4;
  localparam logic [2:0] OFS_LSR  = 3'd5;
  localparam logic [2:0] OFS_MSR  = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  localparam int IER_W        = 4;
  localparam int MCR_W        = 5;
  localparam int LCR_DIV_BIT  = 7;
  localparam int MCR_LOOP_BIT = 4;

  localparam int LSR_DR   = 0;
  localparam int LSR_OE   = 1;
  localparam int LSR_BI   = 4;
  localparam int LSR_THRE = 5;
  localparam int LSR_TEMT = 6;

  typedef enum logic [2:0] {
    IIR_NONE = 3'b001,
    IIR_TX   = 3'b010,
    IIR_RX   = 3'b100
  } iir_code_t;
endpackage

// File: rtl/uart_rf_rx.sv
module uart_rf_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_byte_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_break,
  input  logic          buf_rd,
  input  logic          stat_rd,
  output logic [DW-1:0] buf_q,
  output logic          ready_q,
  output logic          brk_q,
  output logic          ovr_q
);
  logic [DW-1:0] buf_n;
  logic          ready_n, brk_n, ovr_n;
  logic          arrive;

  assign arrive = rx_byte_valid | rx_break;

  always_comb begin
    buf_n   = buf_q;
    ready_n = ready_q;
    brk_n   = brk_q;
    ovr_n   = ovr_q;
    if (buf_rd) begin
      ready_n = 1'b0;
      brk_n   = 1'b0;
    end
    if (stat_rd) ovr_n = 1'b0;
    if (arrive && ready_q && !buf_rd) ovr_n = 1'b1;
    if (rx_break) begin
      buf_n   = '0;
      brk_n   = 1'b1;
      ready_n = 1'b1;
    end else if (rx_byte_valid) begin
      buf_n   = rx_byte;
      ready_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      ready_q <= 1'b0;
      brk_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      buf_q   <= buf_n;
      ready_q <= ready_n;
      brk_q   <= brk_n;
      ovr_q   <= ovr_n;
    end
  end
endmodule

// File: rtl/uart_rf_txirq.sv
module uart_rf_txirq
  import uart_rf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_wr,
  input  logic       tx_accept,
  input  logic       en_wr,
  input  logic       id_rd,
  input  logic       rx_ready,
  input  logic [1:0] src_en,
  output logic       hold_empty_q,
  output logic       shift_empty_q,
  output logic       tx_pend_q,
  output iir_code_t  code,
  output logic       irq
);
  logic hold_empty_n, shift_empty_n, tx_pend_n;

  always_comb begin
    if (rx_ready && src_en[0])        code = IIR_RX;
    else if (tx_pend_q && src_en[1])  code = IIR_TX;
    else                              code = IIR_NONE;
  end

  assign irq = (code != IIR_NONE);

  always_comb begin
    hold_empty_n  = hold_empty_q;
    shift_empty_n = shift_empty_q;
    tx_pend_n     = tx_pend_q;
    if (id_rd && code == IIR_TX) tx_pend_n = 1'b0;
    if ((en_wr && hold_empty_q) || tx_accept) tx_pend_n = 1'b1;
    if (tx_accept) begin
      hold_empty_n  = 1'b1;
      shift_empty_n = 1'b1;
    end
    if (hold_wr) begin
      hold_empty_n  = 1'b0;
      shift_empty_n = 1'b0;
      tx_pend_n     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_empty_q  <= 1'b1;
      shift_empty_q <= 1'b1;
      tx_pend_q     <= 1'b0;
    end else begin
      hold_empty_q  <= hold_empty_n;
      shift_empty_q <= shift_empty_n;
      tx_pend_q     <= tx_pend_n;
    end
  end
endmodule

// File: rtl/uart_rf_modem.sv
module uart_rf_modem
  import uart_rf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [MCR_W-1:0] mctl,
  output logic [DW-1:0]    mstat
);
  always_comb begin
    mstat = '0;
    if (mctl[MCR_LOOP_BIT]) begin
      mstat[7] = mctl[3];
      mstat[6] = mctl[2];
      mstat[5] = mctl[0];
      mstat[4] = mctl[1];
    end else begin
      mstat[7] = 1'b1;
      mstat[5] = 1'b1;
      mstat[4] = 1'b1;
    end
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      addr,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq,
  output logic [2*DW-1:0] divisor,
  output logic [DW-1:0]   line_ctrl,
  output logic            tx_load,
  output logic [DW-1:0]   tx_byte,
  input  logic            tx_accept,
  input  logic            rx_byte_valid,
  input  logic [DW-1:0]   rx_byte,
  input  logic            rx_break
);
  localparam int LANES = 2;
  localparam int DIV_W = LANES * DW;

  logic [IER_W-1:0] ier_q, ier_n;
  logic [DW-1:0]    lcr_q, lcr_n;
  logic [MCR_W-1:0] mcr_q, mcr_n;
  logic [DW-1:0]    scr_q, scr_n;
  logic [DIV_W-1:0] div_q, div_n;

  logic dlab;
  logic hold_wr, ier_wr, lcr_wr, mcr_wr, scr_wr;
  logic buf_rd, stat_rd, id_rd;

  logic [DW-1:0] rbr_q;
  logic          dr_q, bi_q, oe_q;
  logic          thre_q, temt_q, thr_pend;
  iir_code_t     iir_code;
  logic [DW-1:0] msr_rd, lsr_rd;

  assign dlab    = lcr_q[LCR_DIV_BIT];
  assign hold_wr = wr_en && addr == OFS_DATA && !dlab;
  assign ier_wr  = wr_en && addr == OFS_IER  && !dlab;
  assign lcr_wr  = wr_en && addr == OFS_LCR;
  assign mcr_wr  = wr_en && addr == OFS_MCR;
  assign scr_wr  = wr_en && addr == OFS_SCR;
  assign buf_rd  = rd_en && addr == OFS_DATA && !dlab;
  assign stat_rd = rd_en && addr == OFS_LSR;
  assign id_rd   = rd_en && addr == OFS_IIR;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_div_lane
      logic lane_wr;
      assign lane_wr = wr_en && dlab && addr == 3'(g);
      assign div_n[g*DW +: DW] = lane_wr ? wdata : div_q[g*DW +: DW];
    end
  endgenerate

  always_comb begin
    ier_n = ier_wr ? wdata[IER_W-1:0] : ier_q;
    lcr_n = lcr_wr ? wdata : lcr_q;
    mcr_n = mcr_wr ? wdata[MCR_W-1:0] : mcr_q;
    scr_n = scr_wr ? wdata : scr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0;
      lcr_q <= '0;
      mcr_q <= '0;
      scr_q <= '0;
      div_q <= '0;
    end else begin
      ier_q <= ier_n;
      lcr_q <= lcr_n;
      mcr_q <= mcr_n;
      scr_q <= scr_n;
      div_q <= div_n;
    end
  end

  uart_rf_rx #(.DW(DW)) u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_byte_valid (rx_byte_valid),
    .rx_byte       (rx_byte),
    .rx_break      (rx_break),
    .buf_rd        (buf_rd),
    .stat_rd       (stat_rd),
    .buf_q         (rbr_q),
    .ready_q       (dr_q),
    .brk_q         (bi_q),
    .ovr_q         (oe_q)
  );

  uart_rf_txirq u_txirq (
    .clk           (clk),
    .rst_n         (rst_n),
    .hold_wr       (hold_wr),
    .tx_accept     (tx_accept),
    .en_wr         (ier_wr),
    .id_rd         (id_rd),
    .rx_ready      (dr_q),
    .src_en        (ier_q[1:0]),
    .hold_empty_q  (thre_q),
    .shift_empty_q (temt_q),
    .tx_pend_q     (thr_pend),
    .code          (iir_code),
    .irq           (irq)
  );

  uart_rf_modem #(.DW(DW)) u_modem (
    .mctl  (mcr_q),
    .mstat (msr_rd)
  );

  always_comb begin
    lsr_rd           = '0;
    lsr_rd[LSR_DR]   = dr_q;
    lsr_rd[LSR_OE]   = oe_q;
    lsr_rd[LSR_BI]   = bi_q;
    lsr_rd[LSR_THRE] = thre_q;
    lsr_rd[LSR_TEMT] = temt_q;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_DATA: rdata = dlab ? div_q[DW-1:0] : rbr_q;
        OFS_IER:  rdata = dlab ? div_q[DIV_W-1:DW] : DW'(ier_q);
        OFS_IIR:  rdata = DW'(iir_code);
        OFS_LCR:  rdata = lcr_q;
        OFS_MCR:  rdata = DW'(mcr_q);
        OFS_LSR:  rdata = lsr_rd;
        OFS_MSR:  rdata = msr_rd;
        default:  rdata = scr_q;
      endcase
    end
  end

  assign divisor   = div_q;
  assign line_ctrl = lcr_q;
  assign tx_load   = hold_wr;
  assign tx_byte   = wdata;
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk
  import uart_rf_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       irq,
  input logic       tx_load,
  input logic       tx_accept,
  input logic       rx_byte_valid,
  input logic       rx_break,
  input logic       dlab,
  input logic       dr,
  input logic       bi,
  input logic       oe,
  input logic       thre,
  input logic       thr_pend,
  input logic [3:0] ier,
  input logic [7:0] rbr
);
  p_ier_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_IER && !dlab) |=> (ier == $past(wdata[3:0])));

  p_ier_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_IER && !dlab && thre) |=> thr_pend);

  p_rx_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dr && ier[0]) |-> irq);

  p_id_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_IIR && rdata[2:0] == 3'b010 && !tx_accept) |=> !thr_pend);

  p_load_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (!thre && !thr_pend));

  p_buf_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_DATA && !dlab && !rx_byte_valid && !rx_break) |=> (!dr && !bi));

  p_break_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> (dr && bi && rbr == 8'h00));

  p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_byte_valid || rx_break) && dr && !(rd_en && addr == OFS_DATA && !dlab)) |=> oe);
endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .addr          (addr),
  .rd_en         (rd_en),
  .wr_en         (wr_en),
  .wdata         (wdata),
  .rdata         (rdata),
  .irq           (irq),
  .tx_load       (tx_load),
  .tx_accept     (tx_accept),
  .rx_byte_valid (rx_byte_valid),
  .rx_break      (rx_break),
  .dlab          (dlab),
  .dr            (dr_q),
  .bi            (bi_q),
  .oe            (oe_q),
  .thre          (thre_q),
  .thr_pend      (thr_pend),
  .ier           (ier_q),
  .rbr           (rbr_q)
);

// File: tb/uart_regfile_bench.sv
module uart_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  logic [15:0] divisor;
  logic [7:0]  line_ctrl;
  logic        tx_load;
  logic [7:0]  tx_byte;
  logic        tx_accept = 1'b0;
  logic        rx_byte_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_break = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  // model state built from the requirements
  logic [3:0]  m_ier;
  logic [7:0]  m_lcr, m_scr, m_rbr;
  logic [4:0]  m_mcr;
  logic [15:0] m_div;
  logic        m_dr, m_bi, m_oe, m_thre, m_temt, m_pend;

  always #4 clk = ~clk;

  uart_regfile u_uart_regfile (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .divisor(divisor),
    .line_ctrl(line_ctrl), .tx_load(tx_load), .tx_byte(tx_byte),
    .tx_accept(tx_accept), .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
    .rx_break(rx_break)
  );

  function automatic logic [7:0] m_iir();
    if (m_dr && m_ier[0]) return 8'h04;
    if (m_pend && m_ier[1]) return 8'h02;
    return 8'h01;
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    logic dl = m_lcr[7];
    case (a)
      3'd0: return dl ? m_div[7:0] : m_rbr;
      3'd1: return dl ? m_div[15:8] : {4'h0, m_ier};
      3'd2: return m_iir();
      3'd3: return m_lcr;
      3'd4: return {3'b000, m_mcr};
      3'd5: return {1'b0, m_temt, m_thre, m_bi, 2'b00, m_oe, m_dr};
      3'd6: return m_mcr[4] ? {m_mcr[3], m_mcr[2], m_mcr[0], m_mcr[1], 4'h0} : 8'hB0;
      default: return m_scr;
    endcase
  endfunction

  function automatic string rtag(input logic [2:0] a);
    if (m_lcr[7] && a <= 3'd1) return "R1";
    case (a)
      3'd0: return "R7";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R11";
      3'd4: return "R10";
      3'd5: return "R9";
      3'd6: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic m_reset();
    m_ier = '0; m_lcr = '0; m_scr = '0; m_rbr = '0; m_mcr = '0; m_div = '0;
    m_dr = 0; m_bi = 0; m_oe = 0; m_thre = 1; m_temt = 1; m_pend = 0;
  endtask

  task automatic m_step(input bit we, input bit re, input logic [2:0] a, input logic [7:0] d,
                        input bit rxv, input logic [7:0] rxd, input bit brk, input bit acc);
    logic       dl = m_lcr[7];
    logic [7:0] id = m_iir();
    bit thr_w  = we && a == 3'd0 && !dl;
    bit ier_w  = we && a == 3'd1 && !dl;
    bit buf_r  = re && a == 3'd0 && !dl;
    bit old_dr = m_dr;
    bit old_thre = m_thre;
    if (we) begin
      if (dl && a == 3'd0) m_div[7:0] = d;
      if (dl && a == 3'd1) m_div[15:8] = d;
      if (ier_w) m_ier = d[3:0];
      if (a == 3'd3) m_lcr = d;
      if (a == 3'd4) m_mcr = d[4:0];
      if (a == 3'd7) m_scr = d;
    end
    if (buf_r) begin m_dr = 0; m_bi = 0; end
    if (re && a == 3'd5) m_oe = 0;
    if ((rxv || brk) && old_dr && !buf_r) m_oe = 1;
    if (brk) begin m_rbr = 8'h00; m_bi = 1; m_dr = 1; end
    else if (rxv) begin m_rbr = rxd; m_dr = 1; end
    if (re && a == 3'd2 && id == 8'h02) m_pend = 0;
    if ((ier_w && old_thre) || acc) m_pend = 1;
    if (acc) begin m_thre = 1; m_temt = 1; end
    if (thr_w) begin m_thre = 0; m_temt = 0; m_pend = 0; end
  endtask

  // one bus cycle: drive at falling edge, check combinational outputs, update model at rising edge
  task automatic op(input bit we, input bit re, input logic [2:0] a, input logic [7:0] d,
                    input bit rxv, input logic [7:0] rxd, input bit brk, input bit acc);
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wdata = d;
    rx_byte_valid = rxv; rx_byte = rxd; rx_break = brk; tx_accept = acc;
    #1;
    // R12: read data in the same cycle as the strobe, zero otherwise
    if (re) chk(rtag(a), {8'h00, rdata}, {8'h00, m_read(a)});
    else    chk("R12", {8'h00, rdata}, 16'h0000);
    chk("R4", {15'h0, irq}, {15'h0, m_iir() != 8'h01});
    chk("R1", divisor, m_div);
    chk("R11", {8'h00, line_ctrl}, {8'h00, m_lcr});
    chk("R6", {15'h0, tx_load}, {15'h0, we && a == 3'd0 && !m_lcr[7]});
    if (tx_load) chk("R6", {8'h00, tx_byte}, {8'h00, d});
    @(posedge clk);
    m_step(we, re, a, d, rxv, rxd, brk, acc);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    op(1, 0, a, d, 0, 8'h00, 0, 0);
  endtask
  task automatic rd(input logic [2:0] a);
    op(0, 1, a, 8'h00, 0, 8'h00, 0, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 reset values
    rd(3'd5); rd(3'd2); rd(3'd6); rd(3'd1); rd(3'd7);

    // R1 divisor access
    wr(3'd3, 8'h80); wr(3'd0, 8'h34); wr(3'd1, 8'h12);
    rd(3'd0); rd(3'd1); wr(3'd3, 8'h03); rd(3'd1);

    // R3 enable mask and arming, R5 identification read clears pending
    wr(3'd1, 8'hFF); rd(3'd1); rd(3'd2); rd(3'd2);
    wr(3'd1, 8'h02); rd(3'd2);

    // R6 transmit load and accept
    wr(3'd0, 8'h55); rd(3'd5); rd(3'd2);
    op(0, 0, 3'd0, 8'h00, 0, 8'h00, 0, 1); rd(3'd5); rd(3'd2);
    wr(3'd0, 8'hAA); op(0, 0, 3'd0, 8'h00, 0, 8'h00, 0, 1);

    // R7 receive, R4 priority, R9 overrun, R8 break
    wr(3'd1, 8'h03);
    op(0, 0, 3'd0, 8'h00, 1, 8'hA5, 0, 0); rd(3'd2);
    op(0, 0, 3'd0, 8'h00, 1, 8'h3C, 0, 0); rd(3'd5); rd(3'd5);
    rd(3'd0); rd(3'd5); rd(3'd2);
    op(0, 1, 3'd0, 8'h00, 1, 8'h77, 0, 0); rd(3'd5);
    op(0, 0, 3'd0, 8'h00, 1, 8'h11, 1, 0); rd(3'd5); rd(3'd0); rd(3'd5);
    op(0, 1, 3'd5, 8'h00, 1, 8'h22, 0, 0); rd(3'd5); rd(3'd0);

    // R10 loopback and masking
    wr(3'd4, 8'hFF); rd(3'd4); rd(3'd6);
    wr(3'd4, 8'h15); rd(3'd6);
    wr(3'd4, 8'h1A); rd(3'd6);
    wr(3'd4, 8'h0F); rd(3'd6);

    // R11 ignored writes and scratch
    wr(3'd2, 8'hFF); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF);
    rd(3'd2); rd(3'd5); rd(3'd6);
    wr(3'd7, 8'h5A); rd(3'd7);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int  k   = int'($urandom_range(0, 9));
      bit  we  = (k < 4);
      bit  re  = (k >= 4 && k < 8);
      logic [2:0] a = 3'($urandom_range(0, 7));
      logic [7:0] d = 8'($urandom);
      if (we && a == 3'd3 && ($urandom_range(0, 3) != 0)) d[7] = 1'b0;
      op(we, re, a, d, $urandom_range(0, 5) == 0, 8'($urandom),
         $urandom_range(0, 19) == 0, $urandom_range(0, 3) == 0);
    end

    @(negedge clk);
    wr_en = 0; rd_en = 0; rx_byte_valid = 0; rx_break = 0; tx_accept = 0;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule